// File: doc/BRIEF.md
# Sample Packet UART Receiver

This block terminates one serial data lane that carries sensor samples from a remote acquisition board. It takes the raw asynchronous line, brings it into the local clock domain, recovers characters, and checks each one for parity and framing. The recovered bytes are then assembled into a set of four samples. On the wire, each sample travels as a three-byte packet: a header byte whose value names the slot, then the sample's upper byte, then its lower byte.

When all twelve bytes of a set arrive clean and in sequence, the four 16-bit samples are published together on one wide output, and a one-clock strobe marks the update. Any bad character or out-of-order header throws away the partial set and raises a single-cycle error flag. The receiver then waits quietly for the next first-slot header. The published samples keep their last good values until a new set completes, so a controller can read them at any time.

Top module: `pkt_uart_rx`

## Requirements
- R1: A character is a low start bit, then 8 data bits least significant bit first, then a parity bit, then two stop bits. Each bit lasts 16 sample ticks, and with the default settings one tick is one clock.
- R2: Each bit value is the majority of three line samples taken around the middle of the bit, so a single-tick glitch at mid-bit does not change the received value.
- R3: If the line is back high at the middle of a start bit, the receiver returns to idle and produces no character.
- R4: The parity bit must make the count of ones across the 8 data bits and the parity bit odd. If it does not, `parity_err` pulses for one clock and the partial set is discarded.
- R5: A low level in either stop-bit position makes `frame_err` pulse for one clock and discards the partial set. A character can raise `parity_err` and `frame_err` in the same cycle.
- R6: Slot k (k = 0..3) must begin with the header byte 0x90 + k. A header byte of any other value pulses `seq_err` for one clock and discards the partial set. No error flag is ever raised in the same cycle as `set_valid`.
- R7: After an error, and after reset, bytes are dropped without any flag until a good 0x90 arrives. A mismatching header that is itself 0x90 flags `seq_err` and, in the same cycle, starts a new set with that byte as its first header.
- R8: Each sample is rebuilt as {upper byte, lower byte}, and slot k drives `samples[16k+15:16k]`. `set_valid` is high for exactly one clock, one cycle after the twelfth good byte. `samples` changes only in that cycle and otherwise holds its value, including across errors.
- R9: After reset, `samples` is zero and `set_valid`, `parity_err`, `frame_err` and `seq_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| samples | output | 64 | Four 16-bit samples; slot k at bits 16k+15:16k |
| set_valid | output | 1 | One-clock strobe when a full set has been published |
| parity_err | output | 1 | One-clock pulse for a character with bad parity |
| frame_err | output | 1 | One-clock pulse for a character with a low stop bit |
| seq_err | output | 1 | One-clock pulse for a header out of sequence |

## Verification
Error detection and set restart can happen in the same cycle. A header 0x90 arriving in the slot that should hold 0x91 must both raise `seq_err` and begin a new set. The bench provokes this by injecting a stray 0x90 three bytes into a set and then sending the eleven remaining bytes of a fresh set. The scoreboard must see a `seq_err` event followed by a `set_valid` carrying the fresh samples. A character with both bad parity and a low stop bit is also sent, and it must raise both flags together as one event.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP1,
    S_STOP2
  } rx_state_e;

  // majority of three line samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // odd parity holds when data plus parity bit carry an odd count of ones
  function automatic logic odd_ok(input logic [BYTE_W-1:0] d, input logic p);
    return ^{d, p};
  endfunction

  // header value expected at the start of a given slot
  function automatic logic [BYTE_W-1:0] exp_header(input logic [BYTE_W-1:0] base,
                                                    input int unsigned slot);
    return base + BYTE_W'(slot);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_char_engine.sv
module rx_char_engine
  import pkt_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxs,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;

  logic tick;

  generate
    if (TICK_DIV <= 1) begin : g_full_rate
      assign tick = 1'b1;
    end else begin : g_divided
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (rst)                               div_cnt <= '0;
        else if (div_cnt == DW'(TICK_DIV - 1)) div_cnt <= '0;
        else                                   div_cnt <= div_cnt + 1'b1;
      end
      assign tick = (div_cnt == DW'(TICK_DIV - 1));
    end
  endgenerate

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic              v0, v1;
  logic [2:0]        bitn;
  logic [BYTE_W-1:0] sh;
  logic              pbit, s1;

  // named internal events
  logic active, decide, bit_end, bit_val;
  assign active  = tick && (st != S_IDLE);
  assign decide  = active && (cnt == CW'(MID + 1));
  assign bit_end = active && (cnt == CW'(OVERSAMPLE - 1));
  assign bit_val = maj3(v0, v1, rxs);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      v0   <= 1'b1;
      v1   <= 1'b1;
      bitn <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      s1   <= 1'b1;
      done <= 1'b0;
      data <= '0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick && st == S_IDLE) begin
        if (!rxs) begin
          st  <= S_START;
          cnt <= CW'(1);
        end
      end else if (active) begin
        cnt <= bit_end ? '0 : cnt + 1'b1;
        if (cnt == CW'(MID - 1)) v0 <= rxs;
        if (cnt == CW'(MID))     v1 <= rxs;
        if (decide) begin
          case (st)
            S_START: if (bit_val) st <= S_IDLE;
            S_DATA:  sh   <= {bit_val, sh[BYTE_W-1:1]};
            S_PAR:   pbit <= bit_val;
            S_STOP1: s1   <= bit_val;
            S_STOP2: begin
              done <= 1'b1;
              data <= sh;
              perr <= !odd_ok(sh, pbit);
              ferr <= !(s1 && bit_val);
              st   <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
        if (bit_end) begin
          case (st)
            S_START: begin st <= S_DATA; bitn <= '0; end
            S_DATA: begin
              bitn <= bitn + 1'b1;
              if (bitn == 3'd7) st <= S_PAR;
            end
            S_PAR:   st <= S_STOP1;
            S_STOP1: st <= S_STOP2;
            default: ;
          endcase
        end
      end
    end
  end

  // R3: a start bit that reads high at its middle returns to idle with no character
  p_start_abort_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && decide && bit_val) |=> (st == S_IDLE && !done));

  // R1: a character is only delivered out of the second stop bit
  p_done_from_stop_r1: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st == S_STOP2 && decide));

  // R1: the delivery strobe never lasts more than one cycle
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/rx_set_parser.sv
module rx_set_parser
  import pkt_rx_pkg::*;
#(
  parameter int              NUM_SLOTS = 4,
  parameter logic [7:0]      HDR_BASE  = 8'h90
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ch_done,
  input  logic [BYTE_W-1:0]               ch_data,
  input  logic                            ch_perr,
  input  logic                            ch_ferr,
  output logic [NUM_SLOTS*SAMPLE_W-1:0]   samples,
  output logic                            set_valid,
  output logic                            perr_flag,
  output logic                            ferr_flag,
  output logic                            seq_flag
);
  localparam int SW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  typedef enum logic [1:0] {PH_HDR, PH_HI, PH_LO} phase_e;

  phase_e                              phase;
  logic [SW-1:0]                       slot;
  logic                                hunt;
  logic [BYTE_W-1:0]                   hi_byte;
  logic [NUM_SLOTS-1:0][SAMPLE_W-1:0]  shadow, shadow_nx, pub;

  // named internal events
  logic good_char, bad_char, hdr_pos, hdr_match, is_first, set_done, silent_drop;
  assign good_char   = ch_done && !ch_perr && !ch_ferr;
  assign bad_char    = ch_done && (ch_perr || ch_ferr);
  assign hdr_pos     = good_char && phase == PH_HDR;
  assign hdr_match   = ch_data == exp_header(HDR_BASE, 32'(slot));
  assign is_first    = ch_data == HDR_BASE;
  assign set_done    = good_char && phase == PH_LO && slot == SW'(NUM_SLOTS - 1);
  assign silent_drop = hdr_pos && !hdr_match && hunt;

  always_comb begin
    shadow_nx       = shadow;
    shadow_nx[slot] = {hi_byte, ch_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_HDR;
      slot      <= '0;
      hunt      <= 1'b1;
      hi_byte   <= '0;
      shadow    <= '0;
      pub       <= '0;
      set_valid <= 1'b0;
      perr_flag <= 1'b0;
      ferr_flag <= 1'b0;
      seq_flag  <= 1'b0;
    end else begin
      set_valid <= 1'b0;
      perr_flag <= 1'b0;
      ferr_flag <= 1'b0;
      seq_flag  <= 1'b0;
      if (bad_char) begin
        perr_flag <= ch_perr;
        ferr_flag <= ch_ferr;
        phase     <= PH_HDR;
        slot      <= '0;
        hunt      <= 1'b1;
      end else if (hdr_pos) begin
        if (hdr_match) begin
          phase <= PH_HI;
          hunt  <= 1'b0;
        end else begin
          if (!hunt) seq_flag <= 1'b1;
          if (is_first) begin
            phase <= PH_HI;
            slot  <= '0;
            hunt  <= 1'b0;
          end else begin
            phase <= PH_HDR;
            slot  <= '0;
            hunt  <= 1'b1;
          end
        end
      end else if (good_char && phase == PH_HI) begin
        hi_byte <= ch_data;
        phase   <= PH_LO;
      end else if (good_char && phase == PH_LO) begin
        shadow <= shadow_nx;
        phase  <= PH_HDR;
        if (set_done) begin
          pub       <= shadow_nx;
          set_valid <= 1'b1;
          slot      <= '0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  assign samples = pub;

  // R8: the publish strobe is a single cycle
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> !set_valid);

  // R8: published samples only move together with the strobe
  p_hold_samples_r8: assert property (@(posedge clk) disable iff (rst)
    !set_valid |-> $stable(samples));

  // R6: no error flag shares a cycle with a publish
  p_no_err_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (perr_flag || ferr_flag || seq_flag) |-> !set_valid);

  // R7: a byte dropped while hunting raises no flag
  p_hunt_silent_r7: assert property (@(posedge clk) disable iff (rst)
    silent_drop |=> !seq_flag);
endmodule

// File: rtl/pkt_uart_rx.sv
module pkt_uart_rx
  import pkt_rx_pkg::*;
#(
  parameter int         OVERSAMPLE  = 16,
  parameter int         TICK_DIV    = 1,
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_SLOTS   = 4,
  parameter logic [7:0] HDR_BASE    = 8'h90
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rx_line,
  output logic [NUM_SLOTS*SAMPLE_W-1:0] samples,
  output logic                          set_valid,
  output logic                          parity_err,
  output logic                          frame_err,
  output logic                          seq_err
);
  logic              rxs;
  logic              ch_done, ch_perr, ch_ferr;
  logic [BYTE_W-1:0] ch_data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .dout(rxs)
  );

  rx_char_engine #(.OVERSAMPLE(OVERSAMPLE), .TICK_DIV(TICK_DIV)) u_char (
    .clk (clk),
    .rst (rst),
    .rxs (rxs),
    .done(ch_done),
    .data(ch_data),
    .perr(ch_perr),
    .ferr(ch_ferr)
  );

  rx_set_parser #(.NUM_SLOTS(NUM_SLOTS), .HDR_BASE(HDR_BASE)) u_parse (
    .clk      (clk),
    .rst      (rst),
    .ch_done  (ch_done),
    .ch_data  (ch_data),
    .ch_perr  (ch_perr),
    .ch_ferr  (ch_ferr),
    .samples  (samples),
    .set_valid(set_valid),
    .perr_flag(parity_err),
    .ferr_flag(frame_err),
    .seq_flag (seq_err)
  );

  // R5: every flag or publish follows a delivered character by one cycle
  p_flag_after_char_r5: assert property (@(posedge clk) disable iff (rst)
    (set_valid || parity_err || frame_err || seq_err) |-> $past(ch_done));

  // R4: a parity flag stems from a character the engine marked bad
  p_parity_source_r4: assert property (@(posedge clk) disable iff (rst)
    parity_err |-> $past(ch_perr));
endmodule

// File: tb/tb_pkt_uart_rx.sv
module tb_pkt_uart_rx;
  localparam int BIT_CLKS = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic [63:0] samples;
  logic        set_valid, parity_err, frame_err, seq_err;

  pkt_uart_rx dut (
    .clk       (clk),
    .rst       (rst),
    .rx_line   (rx_line),
    .samples   (samples),
    .set_valid (set_valid),
    .parity_err(parity_err),
    .frame_err (frame_err),
    .seq_err   (seq_err)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [3:0]  kind;   // {valid, parity, frame, seq}
    logic [63:0] samp;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [63:0] last_good = '0;
  bit          done_run = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_ev(input logic [3:0] kind, input logic [63:0] s, input string req);
    exp_t e;
    e.kind = kind; e.samp = s; e.req = req;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && (set_valid || parity_err || frame_err || seq_err)) begin
      logic [3:0] k;
      k = {set_valid, parity_err, frame_err, seq_err};
      if (q.size() == 0) begin
        check(0, "unexpected event", {60'd0, k}, 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(k == e.kind, {e.req, " event kind"}, {60'd0, k}, {60'd0, e.kind});
        if (set_valid) begin
          check(samples == e.samp, {e.req, " samples"}, samples, e.samp);
          last_good = e.samp;
        end
      end
    end
  end

  // serial driver: odd parity bit is the inverted xor of the data
  task automatic send_char(input logic [7:0] b, input bit bad_par = 0, input bit bad_s1 = 0,
                           input bit bad_s2 = 0, input int glitch = -1);
    logic [11:0] fr;
    fr[0]    = 1'b0;
    fr[8:1]  = b;
    fr[9]    = ~(^b) ^ bad_par;
    fr[10]   = ~bad_s1;
    fr[11]   = ~bad_s2;
    for (int i = 0; i < 12; i++) begin
      for (int c = 0; c < BIT_CLKS; c++) begin
        rx_line = (glitch == i && c == BIT_CLKS / 2) ? ~fr[i] : fr[i];
        @(negedge clk);
      end
    end
    rx_line = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [63:0] pack4(input logic [15:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic send_set(input logic [63:0] s, input string req, input bit glitchy = 0);
    expect_ev(4'b1000, s, req);
    for (int k = 0; k < 4; k++) begin
      send_char(8'h90 + 8'(k), 0, 0, 0, glitchy ? 1 + k : -1);
      send_char(s[16*k+8 +: 8], 0, 0, 0, glitchy ? 3 + k : -1);
      send_char(s[16*k +: 8],   0, 0, 0, glitchy ? 8 - k : -1);
    end
  endtask

  task automatic drain;
    repeat (40) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", 64'(q.size()), 64'd0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] sa, sb, sc, sd, se, sf, sg;
    sa = pack4(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
    sb = pack4(16'h0000, 16'hFFFF, 16'h8001, 16'h7FFE);
    sc = pack4(16'hA55A, 16'h0F0F, 16'h3C3C, 16'hC001);
    sd = pack4(16'h1111, 16'h2222, 16'h3333, 16'h4444);
    se = pack4(16'hA1A2, 16'hB1B2, 16'hC1C2, 16'hD1D2);
    sf = pack4(16'h0102, 16'h0304, 16'h0506, 16'h0708);
    sg = pack4(16'h7A7B, 16'h6C6D, 16'h5E5F, 16'h4142);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(samples == 64'd0, "R9 samples after reset", samples, 64'd0);
    check({set_valid, parity_err, frame_err, seq_err} == 4'b0, "R9 strobes after reset",
          {60'd0, set_valid, parity_err, frame_err, seq_err}, 64'd0);

    // R1 R8 R6: normal sets
    send_set(sa, "R1 R8 set A");
    drain();
    send_set(sb, "R8 set B extremes");
    drain();

    // R2: mid-bit glitches do not corrupt
    send_set(sc, "R2 glitch set", 1);
    drain();

    // R3: short low pulse is ignored
    rx_line = 1'b0; repeat (4) @(negedge clk);
    rx_line = 1'b1; repeat (40) @(negedge clk);
    check(samples == sc, "R3 false start leaves samples", samples, sc);
    send_set(sd, "R3 set after false start");
    drain();

    // R4: parity error mid-set, remaining bytes dropped silently (R7)
    expect_ev(4'b0100, '0, "R4 parity error");
    send_char(8'h90); send_char(8'h21); send_char(8'h22);
    send_char(8'h91); send_char(8'h23); send_char(8'h24, 1);
    send_char(8'h92); send_char(8'h25); send_char(8'h26);
    send_char(8'h55);
    drain();
    check(samples == sd, "R8 samples held after parity error", samples, sd);
    send_set(se, "R7 resync after parity error");
    drain();

    // R5: low first stop bit
    expect_ev(4'b0010, '0, "R5 stop1 low");
    send_char(8'h90); send_char(8'h31, 0, 1);
    drain();
    // R5: low second stop bit
    expect_ev(4'b0010, '0, "R5 stop2 low");
    send_char(8'h90); send_char(8'h32); send_char(8'h33, 0, 0, 1);
    drain();
    // R5 R4: both faults in one character
    expect_ev(4'b0110, '0, "R5 parity and frame together");
    send_char(8'h44, 1, 1);
    drain();
    check(samples == se, "R8 samples held after frame errors", samples, se);
    send_set(sf, "R5 set after frame errors");
    drain();

    // R6: wrong first header after a completed set
    expect_ev(4'b0001, '0, "R6 wrong first header");
    send_char(8'h91);
    send_char(8'h12);
    drain();
    send_set(sg, "R6 set after sequence error");
    drain();

    // R6: wrong slot-2 header value
    expect_ev(4'b0001, '0, "R6 wrong slot header");
    send_char(8'h90); send_char(8'h01); send_char(8'h02);
    send_char(8'h91); send_char(8'h03); send_char(8'h04);
    send_char(8'h77);
    drain();
    check(samples == sg, "R8 samples held after sequence error", samples, sg);

    // R7: stray 0x90 in slot 1 flags and restarts in the same cycle
    expect_ev(4'b0001, '0, "R7 stray first header");
    expect_ev(4'b1000, sa, "R7 set restarted by stray header");
    send_char(8'h90); send_char(8'h12); send_char(8'h34);
    send_char(8'h90); send_char(sa[15:8]);  send_char(sa[7:0]);
    send_char(8'h91); send_char(sa[31:24]); send_char(sa[23:16]);
    send_char(8'h92); send_char(sa[47:40]); send_char(sa[39:32]);
    send_char(8'h93); send_char(sa[63:56]); send_char(sa[55:48]);
    drain();
    check(samples == sa, "R8 final samples", samples, sa);

    done_run = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule